// File: doc/BRIEF.md
# Burst Address Generator with Dual Strobes

This block supplies the array address for a four-beat cache-line burst. A burst begins when either of two active-low address strobes is seen on a rising clock edge. One strobe comes from the processor and the other from the cache controller. The block then captures a 17-bit starting address. The upper 15 bits are held for the whole burst. The two low bits come from a wrapping beat counter, so later beats need no new address input.

An active-low advance input steps the beat counter on each edge where no strobe is present. The low bits follow one of two orders. In interleaved order they are the start value XOR the beat count. In linear order they are the start value plus the beat count, modulo four. The order input is sampled when the burst loads.

The processor strobe only counts while the active-low chip enable is asserted. The controller strobe works at any time. A strobe always wins over advance. The outputs are the current address and a flag that marks a burst in progress.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, `addr_out` is 0 and `burst_active` is 0.
- R2: A low `proc_strobe_n` with a low `chip_en_n` at a rising edge loads the address. After that edge, `addr_out` equals the sampled `addr_in` and `burst_active` is 1.
- R3: A low `proc_strobe_n` while `chip_en_n` is high has no effect. If no other strobe and no advance is present, `addr_out` and `burst_active` keep their values.
- R4: A low `ctrl_strobe_n` at a rising edge loads `addr_in` and sets `burst_active` to 1, whatever the level of `chip_en_n`.
- R5: A valid strobe overrides `adv_n`. When both strobes are valid in the same cycle, the processor strobe is taken. Either way, the loaded beat is the sampled `addr_in`.
- R6: With `seq_interleave` = 1 at load, each advance (`adv_n` low, no valid strobe) moves to the next beat count b (0,1,2,3, wrapping). `addr_out[1:0]` = start[1:0] XOR b.
- R7: With `seq_interleave` = 0 at load, `addr_out[1:0]` = (start[1:0] + b) mod 4.
- R8: The order is the one captured at the load. Changes to `seq_interleave` during a burst have no effect until the next load.
- R9: `addr_out[16:2]` changes only on a load.
- R10: With no valid strobe and `adv_n` high, `addr_out` and `burst_active` hold.
- R11: An advance from beat count 3 clears `burst_active` and wraps the address back to the start beat. Further advances keep wrapping with `burst_active` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | 17 | Starting address sampled on a load |
| proc_strobe_n | input | 1 | Processor address strobe, active low, gated by chip enable |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| chip_en_n | input | 1 | Active-low chip enable that qualifies the processor strobe |
| adv_n | input | 1 | Active-low advance to the next beat |
| seq_interleave | input | 1 | 1 selects interleaved order, 0 selects linear, sampled at load |
| addr_out | output | 17 | Current array address |
| burst_active | output | 1 | 1 from a load until the advance past the fourth beat |

## Verification
The bench runs every start value under both orders. A design that mixed up XOR and add would fail on the odd start values, where the two orders diverge.

It also sends a processor strobe while the chip is deselected, and a controller strobe in the same deselected state. A design that gated the wrong strobe would either load when it should not or miss a load.

Further cases flip the order input in the middle of a burst and assert a strobe together with advance. A design would fail here if it read the order live or stepped instead of reloading.

The bench also advances past the fourth beat. A design that did not wrap, or kept `burst_active` high, would show the wrong address or flag.

// File: rtl/bag_pkg.sv
package bag_pkg;
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_PROC = 2'd1,
        SRC_CTRL = 2'd2
    } load_src_e;
endpackage

// File: rtl/bag_strobe_arb.sv
module bag_strobe_arb
    import bag_pkg::*;
(
    input  logic      proc_strobe_n,
    input  logic      ctrl_strobe_n,
    input  logic      chip_en_n,
    input  logic      adv_n,
    output logic      load,
    output logic      step,
    output load_src_e src
);
    logic proc_ok;

    always_comb begin
        proc_ok = !proc_strobe_n && !chip_en_n;
        if (proc_ok)             src = SRC_PROC;
        else if (!ctrl_strobe_n) src = SRC_CTRL;
        else                     src = SRC_NONE;
        load = (src != SRC_NONE);
        step = !load && !adv_n;
    end
endmodule

// File: rtl/bag_seq_map.sv
module bag_seq_map #(
    parameter int BURST_BITS = 2
) (
    input  logic [BURST_BITS-1:0] start_lo,
    input  logic [BURST_BITS-1:0] beat,
    input  logic                  interleave,
    output logic [BURST_BITS-1:0] addr_lo
);
    logic [BURST_BITS-1:0] xor_lo;
    logic [BURST_BITS-1:0] add_lo;

    always_comb begin
        xor_lo  = start_lo ^ beat;
        add_lo  = start_lo + beat;
        addr_lo = interleave ? xor_lo : add_lo;
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import bag_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int BURST_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              proc_strobe_n,
    input  logic              ctrl_strobe_n,
    input  logic              chip_en_n,
    input  logic              adv_n,
    input  logic              seq_interleave,
    output logic [ADDR_W-1:0] addr_out,
    output logic              burst_active
);
    localparam int UPPER_W = ADDR_W - BURST_BITS;
    localparam logic [BURST_BITS-1:0] BEAT_ONE  = 1;
    localparam logic [BURST_BITS-1:0] BEAT_LAST = '1;

    typedef struct packed {
        logic [UPPER_W-1:0]    upper;
        logic [BURST_BITS-1:0] start_lo;
        logic [BURST_BITS-1:0] beat;
        logic                  interleave;
        logic                  active;
    } state_t;

    state_t    state_d, state_q;
    logic      load, step;
    load_src_e src;
    logic [BURST_BITS-1:0] addr_lo;

    bag_strobe_arb i_arb (
        .proc_strobe_n (proc_strobe_n),
        .ctrl_strobe_n (ctrl_strobe_n),
        .chip_en_n     (chip_en_n),
        .adv_n         (adv_n),
        .load          (load),
        .step          (step),
        .src           (src)
    );

    bag_seq_map #(.BURST_BITS(BURST_BITS)) i_map (
        .start_lo   (state_q.start_lo),
        .beat       (state_q.beat),
        .interleave (state_q.interleave),
        .addr_lo    (addr_lo)
    );

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d.upper      = addr_in[ADDR_W-1:BURST_BITS];
            state_d.start_lo   = addr_in[BURST_BITS-1:0];
            state_d.beat       = '0;
            state_d.interleave = seq_interleave;
            state_d.active     = 1'b1;
        end else if (step) begin
            state_d.beat = state_q.beat + BEAT_ONE;
            if (state_q.beat == BEAT_LAST) state_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign addr_out     = {state_q.upper, addr_lo};
    assign burst_active = state_q.active;

    // Assertions
    assert_proc_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_strobe_n && !chip_en_n) |=> (addr_out == $past(addr_in) && burst_active));

    assert_proc_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_strobe_n && chip_en_n && ctrl_strobe_n && adv_n)
        |=> ($stable(addr_out) && $stable(burst_active)));

    assert_ctrl_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_strobe_n) |=> (addr_out == $past(addr_in) && burst_active));

    assert_strobe_beats_adv_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (src != SRC_NONE && !adv_n) |=> (addr_out[BURST_BITS-1:0] == $past(addr_in[BURST_BITS-1:0])));

    assert_upper_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load) |=> $stable(addr_out[ADDR_W-1:BURST_BITS]));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_strobe_n && ctrl_strobe_n && adv_n) |=> ($stable(addr_out) && $stable(burst_active)));

    assert_wrap_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (step && state_q.beat == BEAT_LAST) |=> !burst_active);
endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] addr_in = '0;
    logic        proc_strobe_n = 1'b1;
    logic        ctrl_strobe_n = 1'b1;
    logic        chip_en_n = 1'b1;
    logic        adv_n = 1'b1;
    logic        seq_interleave = 1'b0;
    logic [16:0] addr_out;
    logic        burst_active;

    always #5 clk = ~clk;

    burst_addr_gen i_burst_addr_gen (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
        .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
        .chip_en_n(chip_en_n), .adv_n(adv_n), .seq_interleave(seq_interleave),
        .addr_out(addr_out), .burst_active(burst_active)
    );

    typedef struct {
        logic [16:0] addr;
        logic        act;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int fails  = 0;

    // independent model
    logic [16:0] m_start = '0;
    logic [1:0]  m_beat  = '0;
    logic        m_ilv   = 1'b0;
    logic        m_act   = 1'b0;

    function automatic logic [16:0] model_addr();
        logic [1:0] lo;
        lo = m_ilv ? (m_start[1:0] ^ m_beat) : 2'(m_start[1:0] + m_beat);
        return {m_start[16:2], lo};
    endfunction

    task automatic cyc(input logic p_n, input logic c_n, input logic ce_n,
                       input logic a_n, input logic ilv, input logic [16:0] a,
                       input string tag);
        exp_t e;
        proc_strobe_n = p_n; ctrl_strobe_n = c_n; chip_en_n = ce_n;
        adv_n = a_n; seq_interleave = ilv; addr_in = a;
        if ((!p_n && !ce_n) || !c_n) begin
            m_start = a; m_beat = 2'd0; m_ilv = ilv; m_act = 1'b1;
        end else if (!a_n) begin
            if (m_beat == 2'd3) m_act = 1'b0;
            m_beat = m_beat + 2'd1;
        end
        e.addr = model_addr(); e.act = m_act; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (addr_out !== e.addr || burst_active !== e.act) begin
                fails++;
                $display("FAIL %s: addr=%h act=%b expected addr=%h act=%b",
                         e.tag, addr_out, burst_active, e.addr, e.act);
            end
        end
    end

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        checks++;
        if (addr_out !== 17'd0 || burst_active !== 1'b0) begin
            fails++;
            $display("FAIL R1: addr=%h act=%b expected addr=0 act=0", addr_out, burst_active);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R7 linear, all starts; R11 wrap
        for (int s = 0; s < 4; s++) begin
            cyc(1, 0, 1, 1, 0, 17'h1AB00 | 17'(s), "R4 ctrl load deselected");
            for (int k = 0; k < 3; k++) cyc(1, 1, 1, 0, 0, '0, "R7 linear step");
            cyc(1, 1, 1, 0, 0, '0, "R11 wrap clears active");
            cyc(1, 1, 1, 0, 0, '0, "R11 keeps wrapping");
        end
        // R6 interleaved, all starts, via processor strobe
        for (int s = 0; s < 4; s++) begin
            cyc(0, 1, 0, 1, 1, 17'h0F3F0 | 17'(s), "R2 proc load");
            for (int k = 0; k < 4; k++) cyc(1, 1, 0, 0, 1, '0, "R6 interleaved step");
        end
        // R10 hold
        cyc(1, 0, 0, 1, 0, 17'h12345, "R4 load");
        cyc(1, 1, 0, 0, 0, '0, "R7 step");
        for (int k = 0; k < 3; k++) cyc(1, 1, 0, 1, 1, 17'h1FFFF, "R10 hold");
        // R3 proc strobe gated by deselect
        cyc(0, 1, 1, 1, 1, 17'h00000, "R3 proc ignored deselected");
        cyc(0, 1, 1, 1, 0, 17'h15555, "R3 proc ignored again");
        // R5 strobe overrides advance; both strobes
        cyc(1, 1, 0, 0, 0, '0, "R7 step");
        cyc(1, 0, 0, 0, 0, 17'h0AAA2, "R5 ctrl overrides adv");
        cyc(0, 0, 0, 0, 1, 17'h1C003, "R5 both strobes");
        // R8 mode flips mid-burst
        cyc(1, 1, 0, 0, 0, '0, "R8 mode ignored mid burst");
        cyc(1, 1, 0, 0, 0, '0, "R8 mode ignored mid burst");
        cyc(1, 1, 0, 0, 0, '0, "R8 mode ignored mid burst");
        // R9 upper fixed while advancing with changing addr_in
        cyc(1, 0, 1, 1, 0, 17'h10001, "R4 load");
        for (int k = 0; k < 6; k++) cyc(1, 1, 0, 0, 1, 17'(k * 4099), "R9 upper fixed");
        proc_strobe_n = 1; ctrl_strobe_n = 1; adv_n = 1;
        @(negedge clk); @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule